// File: doc/BRIEF.md
# Crypto Coprocessor Instruction Engine

This block runs a ten-instruction program interface over a small register bank of four 128-bit registers, each held as four 32-bit words. A controller hands it one instruction at a time (opcode plus one or two register numbers). The engine then walks the addressed register one 32-bit word per cycle, least significant word first. It either moves the words between the bank and an input FIFO, an output FIFO, a block-cipher engine or a hash engine, or it transforms them in place with an incrementer, a masked XOR or a comparator.

A pending flag (`busy`) is raised when an instruction is accepted. It drops when the last word has been handled, and a one-cycle `done` pulse follows. Starting the cipher or hash engine does not wait for its result, so both engines can run at once. Fetching a result stalls until the engine reports idle. An instruction offered while one is pending, or carrying an undefined opcode, is dropped and flagged on `insn_err`.

Opcodes: LOAD=0, WRITE=1, LOADH=2, SGFM=3, FGFM=4, SAES=5, FAES=6, INC=7, XOR=8, EQU=9; values 10 to 15 are undefined. Word k of a register is bits 32k+31..32k.

Top module: `crypto_insn_engine`

## Requirements
- R1: After reset `busy`, `done`, `insn_err` and `equ_flag` are 0 and every bank register reads back as zero.
- R2: LOAD (0) pops four words from the input FIFO into register `ra`, word 0 first. WRITE (1) pushes register `ra` to the output FIFO, word 0 first. Without stalls each holds `busy` high for exactly four cycles, and `done` pulses for one cycle in the cycle after `busy` falls.
- R3: An instruction offered while `busy` is high, or an opcode of 10 to 15, is not executed and causes a one-cycle `insn_err` pulse in the following cycle.
- R4: LOAD makes no progress and does not pop while `in_empty` is high. WRITE makes no progress and does not push while `out_full` is high.
- R5: INC (7) adds one modulo 2^16 to bits 15..0 of register `ra` and leaves bits 127..16 unchanged.
- R6: XOR (8) writes (ra XOR rb) AND `mask` into register `rb` and leaves `ra` unchanged.
- R7: EQU (9) sets `equ_flag` to 1 when registers `ra` and `rb` are equal and to 0 otherwise. The flag keeps its value until the next EQU completes.
- R8: SAES (5) streams register `ra` to the cipher engine with `aes_wr` and pulses `aes_start` with the fourth word. It completes in four cycles without waiting for the result, and it waits only while `aes_idle` is low.
- R9: FAES (6) stalls while `aes_idle` is low, then reads four words with `aes_rd` and stores them into register `ra`.
- R10: LOADH (2) streams `ra` to the hash engine's key input with `gh_hwr`. SGFM (3) streams `ra` with `gh_wr`, pulses `gh_start` with the fourth word and does not wait. FGFM (4) stalls while `gh_idle` is low, then stores the engine result into `ra`.
- R11: A hash instruction runs at full speed (four cycles) while the cipher engine is still busy.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| insn_valid | input | 1 | Instruction offered this cycle |
| insn_op | input | 4 | Opcode |
| insn_ra | input | 2 | First register number |
| insn_rb | input | 2 | Second register number (XOR, EQU) |
| mask | input | 128 | XOR result mask |
| busy | output | 1 | Instruction pending |
| done | output | 1 | Instruction finished (one-cycle pulse) |
| insn_err | output | 1 | Instruction dropped (one-cycle pulse) |
| equ_flag | output | 1 | Result of the last EQU |
| in_data | input | 32 | Input FIFO head word |
| in_empty | input | 1 | Input FIFO empty |
| in_rd | output | 1 | Input FIFO pop |
| out_data | output | 32 | Output FIFO word |
| out_full | input | 1 | Output FIFO full |
| out_wr | output | 1 | Output FIFO push |
| eng_wdata | output | 32 | Word sent to either engine |
| aes_wr | output | 1 | Cipher engine operand word strobe |
| aes_start | output | 1 | Cipher engine start |
| aes_rd | output | 1 | Cipher engine result word strobe |
| aes_rdata | input | 32 | Cipher engine result word |
| aes_idle | input | 1 | Cipher engine idle |
| gh_hwr | output | 1 | Hash engine key word strobe |
| gh_wr | output | 1 | Hash engine data word strobe |
| gh_start | output | 1 | Hash engine start |
| gh_rd | output | 1 | Hash engine result word strobe |
| gh_rdata | input | 32 | Hash engine result word |
| gh_idle | input | 1 | Hash engine idle |

## Verification
The word-level units are exercised from a vector table. XOR runs with a full mask and with a mixed per-word mask, which shows whether the mask is applied to the right word. INC runs on a plain value and on 0xFFFF, which separates a carry that wraps from one that leaks into bit 16. EQU runs on equal operands and on operands that differ only in the top word, which catches a comparator that looks only at the low word. Directed sequences then overlap a hash step with a slow cipher run, hold each FIFO in its stall state, and offer an instruction while one is pending.

// File: rtl/crypto_eng_pkg.sv
package crypto_eng_pkg;
  localparam int WORD_W = 32;
  localparam int WORDS_PER_REG = 4;
  localparam int NUM_REGS = 4;
  localparam int INC_W = 16;

  typedef enum logic [3:0] {
    OP_LOAD  = 4'd0,
    OP_WRITE = 4'd1,
    OP_LOADH = 4'd2,
    OP_SGFM  = 4'd3,
    OP_FGFM  = 4'd4,
    OP_SAES  = 4'd5,
    OP_FAES  = 4'd6,
    OP_INC   = 4'd7,
    OP_XOR   = 4'd8,
    OP_EQU   = 4'd9
  } op_e;
endpackage

// File: rtl/ce_regbank.sv
module ce_regbank #(
  parameter int NREG = 4,
  parameter int WPR  = 4,
  parameter int W    = 32,
  localparam int DEPTH = NREG * WPR,
  localparam int AW    = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [W-1:0]  wr_data,
  input  logic [AW-1:0] rd_addr_a,
  output logic [W-1:0]  rd_data_a,
  input  logic [AW-1:0] rd_addr_b,
  output logic [W-1:0]  rd_data_b
);
  logic [W-1:0] mem_q [DEPTH];

  for (genvar i = 0; i < DEPTH; i++) begin : g_word
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        mem_q[i] <= '0;
      else if (wr_en && wr_addr == AW'(i))
        mem_q[i] <= wr_data;
    end
  end

  assign rd_data_a = mem_q[rd_addr_a];
  assign rd_data_b = mem_q[rd_addr_b];
endmodule

// File: rtl/ce_wordalu.sv
module ce_wordalu
  import crypto_eng_pkg::*;
#(
  parameter int W    = 32,
  parameter int CW   = 2,
  parameter int INCW = 16
) (
  input  op_e           op,
  input  logic [CW-1:0] cnt,
  input  logic [W-1:0]  word_a,
  input  logic [W-1:0]  word_b,
  input  logic [W-1:0]  mask_word,
  output logic [W-1:0]  result,
  output logic          word_eq
);
  always_comb begin
    result = word_a;
    unique case (op)
      OP_INC: begin
        if (cnt == '0)
          result = {word_a[W-1:INCW], word_a[INCW-1:0] + INCW'(1)};
      end
      OP_XOR:  result = (word_a ^ word_b) & mask_word;
      default: result = word_a;
    endcase
  end

  assign word_eq = (word_a == word_b);
endmodule

// File: rtl/ce_ctrl.sv
module ce_ctrl
  import crypto_eng_pkg::*;
#(
  parameter int RW = 2,
  parameter int CW = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          insn_valid,
  input  logic [3:0]    insn_op,
  input  logic [RW-1:0] insn_ra,
  input  logic [RW-1:0] insn_rb,
  input  logic          in_empty,
  input  logic          out_full,
  input  logic          aes_idle,
  input  logic          gh_idle,
  input  logic          word_eq,
  output logic          busy,
  output op_e           op,
  output logic [RW-1:0] ra,
  output logic [RW-1:0] rb,
  output logic [CW-1:0] cnt,
  output logic          step,
  output logic          done,
  output logic          insn_err,
  output logic          equ_flag
);
  localparam logic [CW-1:0] LAST = {CW{1'b1}};

  logic          busy_q, busy_d;
  op_e           op_q, op_d;
  logic [RW-1:0] ra_q, ra_d, rb_q, rb_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          eq_acc_q, eq_acc_d;
  logic          equ_q, equ_d;
  logic          done_q, done_d;
  logic          err_q, err_d;
  logic          legal, ready, accept, last;

  always_comb begin
    legal = (insn_op <= 4'(OP_EQU));
    unique case (op_q)
      OP_LOAD:                   ready = !in_empty;
      OP_WRITE:                  ready = !out_full;
      OP_LOADH, OP_SGFM, OP_FGFM: ready = gh_idle;
      OP_SAES, OP_FAES:          ready = aes_idle;
      default:                   ready = 1'b1;
    endcase
    step   = busy_q && ready;
    last   = step && (cnt_q == LAST);
    accept = insn_valid && !busy_q && legal;

    busy_d   = busy_q;
    op_d     = op_q;
    ra_d     = ra_q;
    rb_d     = rb_q;
    cnt_d    = cnt_q;
    eq_acc_d = eq_acc_q;
    equ_d    = equ_q;

    if (accept) begin
      busy_d = 1'b1;
      op_d   = op_e'(insn_op);
      ra_d   = insn_ra;
      rb_d   = insn_rb;
      cnt_d  = '0;
    end else if (step) begin
      cnt_d = cnt_q + CW'(1);
      if (last)
        busy_d = 1'b0;
    end

    if (step && op_q == OP_EQU) begin
      eq_acc_d = ((cnt_q == '0) ? 1'b1 : eq_acc_q) && word_eq;
      if (last)
        equ_d = eq_acc_d;
    end

    done_d = last;
    err_d  = insn_valid && (busy_q || !legal);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q   <= 1'b0;
      op_q     <= OP_LOAD;
      ra_q     <= '0;
      rb_q     <= '0;
      cnt_q    <= '0;
      eq_acc_q <= 1'b0;
      equ_q    <= 1'b0;
      done_q   <= 1'b0;
      err_q    <= 1'b0;
    end else begin
      busy_q   <= busy_d;
      op_q     <= op_d;
      ra_q     <= ra_d;
      rb_q     <= rb_d;
      cnt_q    <= cnt_d;
      eq_acc_q <= eq_acc_d;
      equ_q    <= equ_d;
      done_q   <= done_d;
      err_q    <= err_d;
    end
  end

  assign busy     = busy_q;
  assign op       = op_q;
  assign ra       = ra_q;
  assign rb       = rb_q;
  assign cnt      = cnt_q;
  assign done     = done_q;
  assign insn_err = err_q;
  assign equ_flag = equ_q;

  // R2: done follows the fall of busy
  a_r2_done_after_busy: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!busy && $past(busy)));
  // R2: busy only rises on an offered instruction
  a_r2_rise_needs_valid: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(insn_valid));
  // R3: an instruction offered while pending is reported
  a_r3_pending_reported: assert property (@(posedge clk) disable iff (!rst_n)
    (insn_valid && busy) |=> insn_err);
  // R7: the flag only moves when an EQU finishes
  a_r7_flag_held: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(equ_flag) |-> ($past(op_q) == OP_EQU && done));
endmodule

// File: rtl/crypto_insn_engine.sv
module crypto_insn_engine
  import crypto_eng_pkg::*;
#(
  parameter int W    = WORD_W,
  parameter int WPR  = WORDS_PER_REG,
  parameter int NREG = NUM_REGS,
  localparam int RW   = $clog2(NREG),
  localparam int CW   = $clog2(WPR),
  localparam int AW   = RW + CW,
  localparam int REGW = W * WPR
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            insn_valid,
  input  logic [3:0]      insn_op,
  input  logic [RW-1:0]   insn_ra,
  input  logic [RW-1:0]   insn_rb,
  input  logic [REGW-1:0] mask,
  output logic            busy,
  output logic            done,
  output logic            insn_err,
  output logic            equ_flag,
  input  logic [W-1:0]    in_data,
  input  logic            in_empty,
  output logic            in_rd,
  output logic [W-1:0]    out_data,
  input  logic            out_full,
  output logic            out_wr,
  output logic [W-1:0]    eng_wdata,
  output logic            aes_wr,
  output logic            aes_start,
  output logic            aes_rd,
  input  logic [W-1:0]    aes_rdata,
  input  logic            aes_idle,
  output logic            gh_hwr,
  output logic            gh_wr,
  output logic            gh_start,
  output logic            gh_rd,
  input  logic [W-1:0]    gh_rdata,
  input  logic            gh_idle
);
  op_e           op;
  logic [RW-1:0] ra, rb;
  logic [CW-1:0] cnt;
  logic          step, word_eq, last_word;
  logic [W-1:0]  word_a, word_b, alu_out, mask_word;
  logic [W-1:0]  mask_words [WPR];
  logic          wr_en;
  logic [AW-1:0] wr_addr;
  logic [W-1:0]  wr_data;

  for (genvar k = 0; k < WPR; k++) begin : g_mask
    assign mask_words[k] = mask[k*W +: W];
  end
  assign mask_word = mask_words[cnt];

  ce_ctrl #(.RW(RW), .CW(CW)) u_ctrl (
    .clk(clk), .rst_n(rst_n),
    .insn_valid(insn_valid), .insn_op(insn_op), .insn_ra(insn_ra), .insn_rb(insn_rb),
    .in_empty(in_empty), .out_full(out_full), .aes_idle(aes_idle), .gh_idle(gh_idle),
    .word_eq(word_eq),
    .busy(busy), .op(op), .ra(ra), .rb(rb), .cnt(cnt), .step(step),
    .done(done), .insn_err(insn_err), .equ_flag(equ_flag)
  );

  ce_regbank #(.NREG(NREG), .WPR(WPR), .W(W)) u_bank (
    .clk(clk), .rst_n(rst_n),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr_a({ra, cnt}), .rd_data_a(word_a),
    .rd_addr_b({rb, cnt}), .rd_data_b(word_b)
  );

  ce_wordalu #(.W(W), .CW(CW), .INCW(INC_W)) u_alu (
    .op(op), .cnt(cnt), .word_a(word_a), .word_b(word_b),
    .mask_word(mask_word), .result(alu_out), .word_eq(word_eq)
  );

  always_comb begin
    last_word = (cnt == {CW{1'b1}});
    in_rd     = step && op == OP_LOAD;
    out_wr    = step && op == OP_WRITE;
    aes_wr    = step && op == OP_SAES;
    aes_start = aes_wr && last_word;
    aes_rd    = step && op == OP_FAES;
    gh_hwr    = step && op == OP_LOADH;
    gh_wr     = step && op == OP_SGFM;
    gh_start  = gh_wr && last_word;
    gh_rd     = step && op == OP_FGFM;

    wr_en   = in_rd || aes_rd || gh_rd ||
              (step && (op == OP_INC || op == OP_XOR));
    wr_addr = {(op == OP_XOR) ? rb : ra, cnt};
    unique case (op)
      OP_LOAD: wr_data = in_data;
      OP_FAES: wr_data = aes_rdata;
      OP_FGFM: wr_data = gh_rdata;
      default: wr_data = alu_out;
    endcase
  end

  assign out_data  = word_a;
  assign eng_wdata = word_a;

  // R4: no pop from an empty FIFO, no push into a full one
  a_r4_no_pop_empty: assert property (@(posedge clk) disable iff (!rst_n)
    in_rd |-> !in_empty);
  a_r4_no_push_full: assert property (@(posedge clk) disable iff (!rst_n)
    out_wr |-> !out_full);
  // R8: the cipher engine is only started when idle
  a_r8_aes_start_idle: assert property (@(posedge clk) disable iff (!rst_n)
    aes_start |-> aes_idle);
  // R10: the hash engine is only started when idle
  a_r10_gh_start_idle: assert property (@(posedge clk) disable iff (!rst_n)
    gh_start |-> gh_idle);
  // R2: at most one data path strobe per cycle
  a_r2_one_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({in_rd, out_wr, aes_wr, aes_rd, gh_hwr, gh_wr, gh_rd}));
endmodule

// File: tb/sim_crypto_insn_engine.sv
`timescale 1ns/1ps
module sim_crypto_insn_engine;
  localparam int AES_LAT = 20;
  localparam int GH_LAT  = 8;

  logic clk = 1'b0;
  logic rst_n;
  always #2.5 clk = ~clk;

  logic         insn_valid;
  logic [3:0]   insn_op;
  logic [1:0]   insn_ra, insn_rb;
  logic [127:0] mask;
  logic busy, done, insn_err, equ_flag;
  logic [31:0] in_data, out_data, eng_wdata, aes_rdata, gh_rdata;
  logic in_empty, in_rd, out_full, out_wr;
  logic aes_wr, aes_start, aes_rd, aes_idle;
  logic gh_hwr, gh_wr, gh_start, gh_rd, gh_idle;

  crypto_insn_engine u0 (
    .clk(clk), .rst_n(rst_n), .insn_valid(insn_valid), .insn_op(insn_op),
    .insn_ra(insn_ra), .insn_rb(insn_rb), .mask(mask),
    .busy(busy), .done(done), .insn_err(insn_err), .equ_flag(equ_flag),
    .in_data(in_data), .in_empty(in_empty), .in_rd(in_rd),
    .out_data(out_data), .out_full(out_full), .out_wr(out_wr),
    .eng_wdata(eng_wdata), .aes_wr(aes_wr), .aes_start(aes_start), .aes_rd(aes_rd),
    .aes_rdata(aes_rdata), .aes_idle(aes_idle),
    .gh_hwr(gh_hwr), .gh_wr(gh_wr), .gh_start(gh_start), .gh_rd(gh_rd),
    .gh_rdata(gh_rdata), .gh_idle(gh_idle)
  );

  // FIFO models
  logic [31:0] in_q [256];
  logic [31:0] out_q [256];
  int in_wp, in_rp, out_n;
  logic in_hold;
  assign in_data  = in_q[in_rp[7:0]];
  assign in_empty = in_hold || (in_rp == in_wp);
  always @(posedge clk) begin
    if (in_rd) in_rp <= in_rp + 1;
    if (out_wr) begin
      out_q[out_n[7:0]] <= out_data;
      out_n <= out_n + 1;
    end
  end

  // stand-in cipher engine: result is the bitwise inverse of the operand
  logic [127:0] aes_in, aes_res;
  int aes_cnt;
  logic [1:0] aes_wi, aes_ri;
  int aes_starts;
  assign aes_idle  = (aes_cnt == 0);
  assign aes_rdata = aes_res[aes_ri*32 +: 32];
  always @(posedge clk) begin
    if (aes_cnt > 0) aes_cnt <= aes_cnt - 1;
    if (aes_wr) begin
      aes_in[aes_wi*32 +: 32] <= eng_wdata;
      aes_wi <= aes_wi + 2'd1;
    end
    if (aes_start) begin
      aes_res <= ~{eng_wdata, aes_in[95:0]};
      aes_cnt <= AES_LAT;
      aes_starts <= aes_starts + 1;
    end
    if (aes_rd) aes_ri <= aes_ri + 2'd1;
  end

  // stand-in hash engine: acc <= acc ^ x ^ h
  logic [127:0] gh_h, gh_x, gh_acc;
  int gh_cnt;
  logic [1:0] gh_hi, gh_wi, gh_ri;
  assign gh_idle  = (gh_cnt == 0);
  assign gh_rdata = gh_acc[gh_ri*32 +: 32];
  always @(posedge clk) begin
    if (gh_cnt > 0) gh_cnt <= gh_cnt - 1;
    if (gh_hwr) begin
      gh_h[gh_hi*32 +: 32] <= eng_wdata;
      gh_hi <= gh_hi + 2'd1;
    end
    if (gh_wr) begin
      gh_x[gh_wi*32 +: 32] <= eng_wdata;
      gh_wi <= gh_wi + 2'd1;
    end
    if (gh_start) begin
      gh_acc <= gh_acc ^ {eng_wdata, gh_x[95:0]} ^ gh_h;
      gh_cnt <= GH_LAT;
    end
    if (gh_rd) gh_ri <= gh_ri + 2'd1;
  end

  int checks = 0, failures = 0;
  bit finished = 0;

  task automatic chk(input bit ok, input string req, input logic [127:0] act,
                     input logic [127:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic issue(input logic [3:0] op, input logic [1:0] ra, input logic [1:0] rb);
    @(negedge clk);
    insn_valid = 1'b1; insn_op = op; insn_ra = ra; insn_rb = rb;
    @(negedge clk);
    insn_valid = 1'b0;
  endtask

  // runs one instruction to completion, returns busy cycles and done seen
  task automatic exec(input logic [3:0] op, input logic [1:0] ra, input logic [1:0] rb,
                      output int cyc, output bit done_seen);
    issue(op, ra, rb);
    cyc = 0;
    while (busy && cyc < 2000) begin
      cyc++;
      @(negedge clk);
    end
    done_seen = done;
  endtask

  task automatic push_reg(input logic [127:0] v);
    for (int k = 0; k < 4; k++) begin
      in_q[in_wp[7:0]] = v[k*32 +: 32];
      in_wp = in_wp + 1;
    end
  endtask

  task automatic load_reg(input logic [1:0] r, input logic [127:0] v);
    int c; bit d;
    push_reg(v);
    exec(4'd0, r, 2'd0, c, d);
  endtask

  task automatic read_reg(input logic [1:0] r, output logic [127:0] v);
    int c; bit d; int s;
    s = out_n;
    exec(4'd1, r, 2'd0, c, d);
    v = {out_q[(s+3) & 255], out_q[(s+2) & 255], out_q[(s+1) & 255], out_q[s & 255]};
  endtask

  // vector table: op, A, B, mask
  localparam logic [3:0] VOP [6] = '{4'd8, 4'd8, 4'd7, 4'd7, 4'd9, 4'd9};
  localparam logic [127:0] VA [6] = '{
    128'h0123_4567_89AB_CDEF_FEDC_BA98_7654_3210,
    128'hFFFF_0000_AAAA_5555_1234_5678_9ABC_DEF0,
    128'h1111_2222_3333_4444_5555_6666_7777_1234,
    128'h9999_8888_7777_6666_5555_4444_ABCD_FFFF,
    128'hDEAD_BEEF_0BAD_F00D_CAFE_BABE_1357_9BDF,
    128'h8000_0000_0000_0000_0000_0000_0000_0001};
  localparam logic [127:0] VB [6] = '{
    128'h0F0F_0F0F_F0F0_F0F0_3333_CCCC_5A5A_A5A5,
    128'h1234_5678_FFFF_0000_0F0F_0F0F_FFFF_FFFF,
    128'h0,
    128'h0,
    128'hDEAD_BEEF_0BAD_F00D_CAFE_BABE_1357_9BDF,
    128'h0000_0000_0000_0000_0000_0000_0000_0001};
  localparam logic [127:0] VM [6] = '{
    {128{1'b1}},
    128'h0000_0000_FFFF_FFFF_0000_FFFF_FFFF_0000,
    {128{1'b1}}, {128{1'b1}}, {128{1'b1}}, {128{1'b1}}};

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      failures++;
      checks++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [127:0] v, e, h0, x0, d0;
    int cyc; bit dn; int n0, r0;
    insn_valid = 0; insn_op = 0; insn_ra = 0; insn_rb = 0; mask = '0;
    in_wp = 0; in_rp = 0; out_n = 0; in_hold = 0; out_full = 0;
    aes_cnt = 0; aes_wi = 0; aes_ri = 0; aes_starts = 0; aes_in = '0; aes_res = '0;
    gh_cnt = 0; gh_hi = 0; gh_wi = 0; gh_ri = 0; gh_h = '0; gh_x = '0; gh_acc = '0;
    rst_n = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);

    // R1 reset state
    chk(!busy && !done && !insn_err && !equ_flag, "R1 flags", {busy, done, insn_err, equ_flag}, 0);
    read_reg(2'd3, v);
    chk(v == 0, "R1 bank zero", v, 0);

    // R2 load/write round trip and timing
    d0 = 128'hA5A5_0001_C3C3_0002_5A5A_0003_3C3C_0004;
    push_reg(d0);
    exec(4'd0, 2'd2, 2'd0, cyc, dn);
    chk(cyc == 4 && dn, "R2 LOAD four cycles then done", cyc, 4);
    n0 = out_n;
    exec(4'd1, 2'd2, 2'd0, cyc, dn);
    chk(cyc == 4 && dn, "R2 WRITE four cycles then done", cyc, 4);
    chk(out_q[n0 & 255] == d0[31:0], "R2 word 0 first", out_q[n0 & 255], d0[31:0]);
    v = {out_q[(n0+3)&255], out_q[(n0+2)&255], out_q[(n0+1)&255], out_q[n0&255]};
    chk(v == d0, "R2 round trip", v, d0);

    // table of word-unit vectors (R5 R6 R7)
    for (int i = 0; i < 6; i++) begin
      load_reg(2'd0, VA[i]);
      load_reg(2'd1, VB[i]);
      mask = VM[i];
      exec(VOP[i], 2'd0, 2'd1, cyc, dn);
      if (VOP[i] == 4'd8) begin
        read_reg(2'd1, v);
        e = (VA[i] ^ VB[i]) & VM[i];
        chk(v == e, "R6 xor masked", v, e);
        read_reg(2'd0, v);
        chk(v == VA[i], "R6 source kept", v, VA[i]);
      end else if (VOP[i] == 4'd7) begin
        read_reg(2'd0, v);
        e = {VA[i][127:16], VA[i][15:0] + 16'd1};
        chk(v == e, "R5 increment low 16", v, e);
      end else begin
        chk(equ_flag == (VA[i] == VB[i]), "R7 equality", equ_flag, VA[i] == VB[i]);
      end
    end

    // R7 flag held across other instructions
    load_reg(2'd0, 128'h5);
    load_reg(2'd1, 128'h5);
    exec(4'd9, 2'd0, 2'd1, cyc, dn);
    exec(4'd7, 2'd0, 2'd0, cyc, dn);
    chk(equ_flag == 1'b1, "R7 flag held after INC", equ_flag, 1);
    exec(4'd9, 2'd0, 2'd1, cyc, dn);
    chk(equ_flag == 1'b0, "R7 flag cleared by next EQU", equ_flag, 0);

    // R4 LOAD stall on empty, R3 pending instruction dropped
    in_hold = 1;
    r0 = in_rp;
    push_reg(128'hCAFE_0000_BEEF_1111_D00D_2222_F00D_3333);
    issue(4'd0, 2'd3, 2'd0);
    issue(4'd7, 2'd3, 2'd0);
    chk(insn_err == 1'b1, "R3 error on pending", insn_err, 1);
    repeat (6) @(negedge clk);
    chk(busy && in_rp == r0, "R4 LOAD stalled while empty", in_rp - r0, 0);
    in_hold = 0;
    while (busy) @(negedge clk);
    read_reg(2'd3, v);
    chk(v == 128'hCAFE_0000_BEEF_1111_D00D_2222_F00D_3333, "R3 dropped INC had no effect",
        v, 128'hCAFE_0000_BEEF_1111_D00D_2222_F00D_3333);

    // R3 undefined opcode
    issue(4'd12, 2'd3, 2'd0);
    chk(insn_err && !busy, "R3 undefined opcode", {insn_err, busy}, 2'b10);
    read_reg(2'd3, v);
    chk(v == 128'hCAFE_0000_BEEF_1111_D00D_2222_F00D_3333, "R3 undefined opcode no effect",
        v, 128'hCAFE_0000_BEEF_1111_D00D_2222_F00D_3333);

    // R4 WRITE stall on full
    out_full = 1;
    n0 = out_n;
    issue(4'd1, 2'd3, 2'd0);
    repeat (6) @(negedge clk);
    chk(busy && out_n == n0, "R4 WRITE stalled while full", out_n - n0, 0);
    out_full = 0;
    while (busy) @(negedge clk);
    chk(out_n == n0 + 4, "R4 WRITE resumes", out_n - n0, 4);

    // R8 R10 R11 engines
    h0 = 128'h0F1E_2D3C_4B5A_6978_8796_A5B4_C3D2_E1F0;
    x0 = 128'h1357_2468_ACE0_BDF1_0246_8ACE_1357_9BDF;
    d0 = 128'h0011_2233_4455_6677_8899_AABB_CCDD_EEFF;
    load_reg(2'd0, d0);
    load_reg(2'd1, h0);
    load_reg(2'd2, x0);
    exec(4'd2, 2'd1, 2'd0, cyc, dn);
    chk(cyc == 4, "R10 LOADH four cycles", cyc, 4);
    exec(4'd5, 2'd0, 2'd0, cyc, dn);
    chk(cyc == 4 && aes_starts == 1, "R8 SAES non-blocking", cyc, 4);
    chk(!aes_idle, "R8 engine running after SAES", aes_idle, 0);
    exec(4'd3, 2'd2, 2'd0, cyc, dn);
    chk(cyc == 4 && !aes_idle, "R11 SGFM overlaps cipher", {cyc[7:0], aes_idle}, {8'd4, 1'b0});
    exec(4'd6, 2'd3, 2'd0, cyc, dn);
    chk(cyc > 4, "R9 FAES stalls until idle", cyc, 5);
    read_reg(2'd3, v);
    chk(v == ~d0, "R9 FAES result stored", v, ~d0);
    exec(4'd4, 2'd1, 2'd0, cyc, dn);
    read_reg(2'd1, v);
    chk(v == (x0 ^ h0), "R10 FGFM result stored", v, x0 ^ h0);

    // R10 FGFM stalls while hash engine busy
    exec(4'd3, 2'd2, 2'd0, cyc, dn);
    exec(4'd4, 2'd0, 2'd0, cyc, dn);
    chk(cyc > 4, "R10 FGFM stalls until idle", cyc, 5);
    read_reg(2'd0, v);
    e = (x0 ^ h0) ^ x0 ^ h0;
    chk(v == e, "R10 second hash step", v, e);

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule